// File: doc/BRIEF.md
# Interrupt-on-Change Mismatch Detector

This block watches an 8-bit input port and raises a change-interrupt flag when an enabled pin differs from a saved copy of the port. The saved copy is refreshed only when the CPU reads or writes the port. Pin levels first pass through a synchronizer chain. For each enabled pin, the synchronized level is compared with the saved copy. The per-pin differences are ORed and registered into a mismatch stage, and that stage sets a sticky flag one cycle later. The registered mismatch also drives a wake-from-sleep request.

Software clears the flag with a clear strobe. The clear only lasts once a port access has removed the mismatch. While a difference remains, the flag is set again, and a set in the same cycle as a clear wins. A power-on reset reloads the saved copy from the synchronized pins, clears every enable and clears the flag. A warm reset clears only the flag and the mismatch stage. The saved copy and the enables survive a warm reset, so a difference that outlives it raises the flag again.

The pad logic, the interrupt controller and sleep sequencing sit outside this block. All strobes are single-cycle, active-high control pins. There is no streaming interface.

Top module: `ioc_detect`

## Requirements
- R1: While `por_i` is high and in the first cycle after it falls, `flag_o` and `wake_o` are 0. Power-on reset clears all enable bits. It loads the snapshot from the synchronized pins, so pins unchanged since reset raise nothing once they are enabled.
- R2: A level change on an enabled pin that no port access absorbs makes `wake_o` 1 three clock edges after the change, when `SYNC_STAGES` is 2. `flag_o` becomes 1 one edge after that.
- R3: A pin whose enable bit is 0 has no effect on `wake_o` or `flag_o`, whatever its level.
- R4: Once set, `flag_o` stays 1 until a clear or a reset removes it, even after the pins return to the snapshot value.
- R5: `clr_i` clears `flag_o` only in a cycle where `wake_o` is 0. In a cycle where `wake_o` is 1, `flag_o` is 1 after the edge, whether or not `clr_i` is high.
- R6: `rd_i` or `wr_i` reloads the snapshot with all synchronized pins together, and `wake_o` is 0 in the cycle after the access. Changes on several pins that occur before one access are all absorbed by it.
- R7: If a change's synchronized value first appears in the same cycle as a port access, the change is absorbed into the snapshot and never sets `flag_o`.
- R8: A warm reset (`wrst_i`) makes `flag_o` and `wake_o` 0 in the next cycle and keeps both the snapshot and the enables. If a mismatch remains, `wake_o` returns one cycle after `wrst_i` falls and `flag_o` returns one cycle after that.
- R9: `flag_o` rises only after a cycle in which `wake_o` was 1.
- R10: A cycle with `en_we_i` high loads `en_wdata_i` into the enable register, where bit i enables pin i. Enabling a pin whose level already differs from the snapshot raises `wake_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Synchronous power-on reset, active high |
| wrst_i | input | 1 | Synchronous warm reset, active high |
| pins_i | input | WIDTH | Asynchronous pin levels |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | WIDTH | Enable register write data, bit i for pin i |
| rd_i | input | 1 | Port read strobe |
| wr_i | input | 1 | Port write strobe |
| clr_i | input | 1 | Flag clear strobe |
| flag_o | output | 1 | Sticky change-interrupt flag |
| wake_o | output | 1 | Wake-from-sleep request (registered mismatch) |

## Verification
The bench uses the default parameters: WIDTH of 8 and SYNC_STAGES of 2. This makes the edge-exact latencies in R2 and R7 predictable. With two synchronizer stages, an access can be placed in exactly the cycle where a new level leaves the synchronizer, which exercises the absorbed-change case. Eight pins are enough to split the enables into halves and to show one access absorbing changes on several pins.

// File: rtl/ioc_pkg.sv
package ioc_pkg;
  localparam int unsigned IOC_WIDTH = 8;
  localparam int unsigned IOC_SYNC  = 2;

  typedef enum logic [1:0] {
    FLG_HOLD  = 2'd0,
    FLG_SET   = 2'd1,
    FLG_CLEAR = 2'd2
  } flag_op_e;
endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) stage_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i) stage_q[s] <= stage_q[s-1];
  end

  assign q_o = stage_q[LAST];
endmodule

// File: rtl/ioc_track.sv
module ioc_track #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic [WIDTH-1:0] pin_s_i,
  input  logic             en_we_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  input  logic             access_i,
  output logic [WIDTH-1:0] diff_o
);
  logic [WIDTH-1:0] en_q;
  logic [WIDTH-1:0] snap_q;

  // enables: cleared only by power-on reset
  always_ff @(posedge clk_i) begin
    if (por_i)        en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  // snapshot: untouched by warm reset
  always_ff @(posedge clk_i) begin
    if (por_i || access_i) snap_q <= pin_s_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_cmp
    assign diff_o[i] = en_q[i] & (pin_s_i[i] ^ snap_q[i]);
  end
endmodule

// File: rtl/ioc_flag.sv
module ioc_flag
  import ioc_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             wrst_i,
  input  logic [WIDTH-1:0] diff_i,
  input  logic             access_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             mism_o
);
  logic     mism_q;
  logic     flag_q;
  flag_op_e op;

  // an access hides the difference it is about to absorb
  always_ff @(posedge clk_i) begin
    if (por_i || wrst_i) mism_q <= 1'b0;
    else                 mism_q <= (|diff_i) & ~access_i;
  end

  always_comb begin
    if (mism_q)     op = FLG_SET;
    else if (clr_i) op = FLG_CLEAR;
    else            op = FLG_HOLD;
  end

  always_ff @(posedge clk_i) begin
    if (por_i || wrst_i) flag_q <= 1'b0;
    else begin
      case (op)
        FLG_SET:   flag_q <= 1'b1;
        FLG_CLEAR: flag_q <= 1'b0;
        default:   flag_q <= flag_q;
      endcase
    end
  end

  assign flag_o = flag_q;
  assign mism_o = mism_q;
endmodule

// File: rtl/ioc_detect.sv
module ioc_detect
  import ioc_pkg::*;
#(
  parameter int unsigned WIDTH       = IOC_WIDTH,
  parameter int unsigned SYNC_STAGES = IOC_SYNC
) (
  input  logic             clk_i,
  input  logic             por_i,
  input  logic             wrst_i,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             en_we_i,
  input  logic [WIDTH-1:0] en_wdata_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic             wake_o
);
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] diff;
  logic             access;

  assign access = rd_i | wr_i;

  ioc_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (pins_i),
    .q_o   (pin_s)
  );

  ioc_track #(.WIDTH(WIDTH)) u_track (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .pin_s_i    (pin_s),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .access_i   (access),
    .diff_o     (diff)
  );

  ioc_flag #(.WIDTH(WIDTH)) u_flag (
    .clk_i    (clk_i),
    .por_i    (por_i),
    .wrst_i   (wrst_i),
    .diff_i   (diff),
    .access_i (access),
    .clr_i    (clr_i),
    .flag_o   (flag_o),
    .mism_o   (wake_o)
  );
endmodule

// File: rtl/ioc_detect_chk.sv
module ioc_detect_chk (
  input logic clk_i,
  input logic por_i,
  input logic wrst_i,
  input logic rd_i,
  input logic wr_i,
  input logic clr_i,
  input logic flag_o,
  input logic wake_o
);
  // R1
  por_quiet_chk: assert property (@(posedge clk_i)
    por_i |=> (!flag_o && !wake_o));

  // R8
  warm_clear_chk: assert property (@(posedge clk_i) disable iff (por_i)
    wrst_i |=> (!flag_o && !wake_o));

  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (por_i || wrst_i)
    wake_o |=> flag_o);

  // R5
  clear_takes_chk: assert property (@(posedge clk_i) disable iff (por_i || wrst_i)
    (clr_i && !wake_o) |=> !flag_o);

  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (por_i || wrst_i)
    (flag_o && !clr_i) |=> flag_o);

  // R6
  access_ends_chk: assert property (@(posedge clk_i) disable iff (por_i || wrst_i)
    (rd_i || wr_i) |=> !wake_o);

  // R9
  rise_after_wake_chk: assert property (@(posedge clk_i) disable iff (por_i || wrst_i)
    $rose(flag_o) |-> $past(wake_o));
endmodule

bind ioc_detect ioc_detect_chk u_chk (
  .clk_i  (clk_i),
  .por_i  (por_i),
  .wrst_i (wrst_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .clr_i  (clr_i),
  .flag_o (flag_o),
  .wake_o (wake_o)
);

// File: tb/ioc_detect_test.sv
module ioc_detect_test;
  logic       clk_i = 1'b0;
  logic       por_i = 1'b1;
  logic       wrst_i = 1'b0;
  logic [7:0] pins_i = 8'hA5;
  logic       en_we_i = 1'b0;
  logic [7:0] en_wdata_i = 8'h00;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       clr_i = 1'b0;
  logic       flag_o;
  logic       wake_o;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4ns clk_i = ~clk_i;

  ioc_detect uut (
    .clk_i      (clk_i),
    .por_i      (por_i),
    .wrst_i     (wrst_i),
    .pins_i     (pins_i),
    .en_we_i    (en_we_i),
    .en_wdata_i (en_wdata_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .clr_i      (clr_i),
    .flag_o     (flag_o),
    .wake_o     (wake_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_en(input logic [7:0] v);
    en_wdata_i = v; en_we_i = 1'b1; tick(1); en_we_i = 1'b0;
  endtask

  task automatic pulse_rd();  rd_i = 1'b1;  tick(1); rd_i = 1'b0;  endtask
  task automatic pulse_wr();  wr_i = 1'b1;  tick(1); wr_i = 1'b0;  endtask
  task automatic pulse_clr(); clr_i = 1'b1; tick(1); clr_i = 1'b0; endtask

  task automatic t_por_start();
    tick(4);
    chk("R1 flag in reset", flag_o, 1'b0);
    por_i = 1'b0;
    tick(1);
    chk("R1 flag after reset", flag_o, 1'b0);
    chk("R1 wake after reset", wake_o, 1'b0);
    write_en(8'hFF);
    tick(6);
    chk("R1 snapshot from pins", wake_o, 1'b0);
    chk("R1 no flag unchanged", flag_o, 1'b0);
  endtask

  task automatic t_latency();
    pins_i = 8'hA4;
    tick(2);
    chk("R2 wake not before 3 edges", wake_o, 1'b0);
    tick(1);
    chk("R2 wake at 3 edges", wake_o, 1'b1);
    chk("R9 flag waits for wake", flag_o, 1'b0);
    tick(1);
    chk("R2 flag at 4 edges", flag_o, 1'b1);
  endtask

  task automatic t_sticky();
    pins_i = 8'hA5;
    tick(6);
    chk("R4 mismatch gone", wake_o, 1'b0);
    chk("R4 flag held", flag_o, 1'b1);
    pulse_clr();
    chk("R5 clear with no mismatch", flag_o, 1'b0);
  endtask

  task automatic t_clear_vs_set();
    pins_i = 8'hA4;
    tick(6);
    chk("R5 flag up", flag_o, 1'b1);
    pulse_clr();
    chk("R5 set beats clear", flag_o, 1'b1);
    pulse_rd();
    chk("R6 read ends mismatch", wake_o, 1'b0);
    pulse_clr();
    chk("R5 clear after read", flag_o, 1'b0);
    tick(6);
    chk("R6 snapshot reloaded", flag_o, 1'b0);
  endtask

  task automatic t_disabled();
    write_en(8'h0F);
    pins_i = 8'h24;
    tick(6);
    chk("R3 disabled pin wake", wake_o, 1'b0);
    chk("R3 disabled pin flag", flag_o, 1'b0);
    write_en(8'hFF);
    chk("R10 not yet", wake_o, 1'b0);
    tick(1);
    chk("R10 enable exposes mismatch", wake_o, 1'b1);
    tick(1);
    chk("R10 flag follows", flag_o, 1'b1);
    pulse_wr();
    chk("R6 write ends mismatch", wake_o, 1'b0);
    pulse_clr();
    chk("R6 clear after write", flag_o, 1'b0);
  endtask

  task automatic t_absorbed();
    pins_i = 8'h25;
    tick(2);
    pulse_rd();
    chk("R7 coincident wake", wake_o, 1'b0);
    tick(6);
    chk("R7 coincident flag", flag_o, 1'b0);
    chk("R7 coincident wake late", wake_o, 1'b0);
  endtask

  task automatic t_multi_pin();
    pins_i = 8'h27;
    tick(6);
    chk("R6 first pin flag", flag_o, 1'b1);
    pins_i = 8'h2F;
    tick(6);
    pulse_rd();
    pulse_clr();
    tick(6);
    chk("R6 both changes absorbed", flag_o, 1'b0);
    chk("R6 both changes wake", wake_o, 1'b0);
  endtask

  task automatic t_warm();
    pins_i = 8'h2E;
    tick(6);
    chk("R8 flag before", flag_o, 1'b1);
    wrst_i = 1'b1; tick(1); wrst_i = 1'b0;
    chk("R8 flag cleared", flag_o, 1'b0);
    chk("R8 wake cleared", wake_o, 1'b0);
    tick(1);
    chk("R8 wake returns", wake_o, 1'b1);
    tick(1);
    chk("R8 flag returns", flag_o, 1'b1);
    pulse_rd();
    pulse_clr();
    chk("R8 cleanup", flag_o, 1'b0);
  endtask

  task automatic t_por_again();
    pins_i = 8'h11;
    por_i = 1'b1;
    tick(3);
    por_i = 1'b0;
    tick(1);
    chk("R1 flag after second reset", flag_o, 1'b0);
    pins_i = 8'h10;
    tick(6);
    chk("R1 enables cleared", wake_o, 1'b0);
    chk("R1 enables cleared flag", flag_o, 1'b0);
    write_en(8'h01);
    tick(1);
    chk("R1 snapshot holds reset pins", wake_o, 1'b1);
  endtask

  initial begin
    tick(1);
    t_por_start();
    t_latency();
    t_sticky();
    t_clear_vs_set();
    t_disabled();
    t_absorbed();
    t_multi_pin();
    t_warm();
    t_por_again();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    #1600us;
    if (!done) begin
      done = 1'b1;
      nvec++;
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule